// File: doc/BRIEF.md
# Multicast Hash Table Filter

This block decides whether a received multicast destination address should be accepted. Twelve bits taken from the two most significant bytes of the 48-bit address form a hash index into a 4096-bit table. The table is stored as 128 words of 32 bits. The upper seven index bits pick the word and the lower five pick the bit. The lookup answers with a one-cycle registered accept flag.

Software fills the table through a word-wide write port and can read any word back. A configuration port holds a global enable and a two-bit window mode. The mode chooses which twelve address bits form the index. A single clear strobe zeroes every word and drops the enable. The block only sees addresses that something upstream has already classified as multicast.

Top module: `mc_hash_filter`

## Requirements
- R1: After reset every table word reads 0, `cfg_enable` is 0, `cfg_mode` is 0, and `hit_valid` and `hit` are 0.
- R2: With mode 0 the index is address bits [47:36].
- R3: With mode 1 the index is address bits [46:35].
- R4: With mode 2 the index is address bits [45:34].
- R5: With mode 3 the index is address bits [43:32]. Address bits [47:44] then have no effect.
- R6: Index bits [11:5] select the table word (0 to 127). Index bits [4:0] select the bit within that word, with bit 0 as the least significant.
- R7: `hit_valid` is 1 in exactly the cycle after a cycle in which `addr_valid` was 1. In that cycle, `hit` equals the selected table bit ANDed with the enable, both taken as they stood before that edge.
- R8: While the enable is 0, `hit` stays 0 whatever the table holds.
- R9: A `table_clear` strobe zeroes all 128 words and clears the enable at the next edge. It overrides a table write in the same cycle and the enable value of a configuration write in the same cycle. The mode is not changed by a clear.
- R10: A table write updates the word at `tbl_wr_sel` at the next edge. `tbl_rd_data` always shows the stored word at `tbl_rd_sel`. A configuration write loads `cfg_enable` and `cfg_mode` at the next edge.
- R11: `hit` is never 1 unless `hit_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_valid | input | 1 | Address strobe requesting a lookup |
| dest_addr | input | 48 | Destination address to classify |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_enable_in | input | 1 | Enable value to write |
| cfg_mode_in | input | 2 | Window mode value to write |
| table_clear | input | 1 | Zero the table and clear the enable |
| tbl_wr | input | 1 | Table word write strobe |
| tbl_wr_sel | input | 7 | Word selected for writing |
| tbl_wr_data | input | 32 | Word value to write |
| tbl_rd_sel | input | 7 | Word selected for reading |
| tbl_rd_data | output | 32 | Stored word at `tbl_rd_sel` |
| cfg_enable | output | 1 | Current enable |
| cfg_mode | output | 2 | Current window mode |
| hit_valid | output | 1 | Lookup result valid |
| hit | output | 1 | Address accepted |

## Verification
The hardest situation to reach from the ports is a collision of commands in one cycle. A clear can land together with a table write, a configuration write and a lookup. The lookup must then still see the old table and enable, while the new state must show the clear winning. The directed part sets these collisions up deliberately. A long random phase then drives every strobe at once with independent probabilities, so clears and writes meet lookups in all orders. Every cycle is compared against a behavioural model. The directed lookups use hand-picked addresses that hit the extreme words (0 and 127) and the extreme bit positions.

// File: rtl/mhf_pkg.sv
// Package: shared types for the multicast hash filter.
// Assumes a 48-bit destination address.
package mhf_pkg;
    localparam int ADDR_W = 48;

    // Which address window forms the hash index.
    typedef enum logic [1:0] {
        WIN_TOP      = 2'd0,
        WIN_DOWN1    = 2'd1,
        WIN_DOWN2    = 2'd2,
        WIN_LOW_BYTE = 2'd3
    } win_mode_t;
endpackage

// File: rtl/mhf_index.sv
// Module: hash index extraction.
// Picks HASH_W consecutive address bits according to the window mode.
// Assumes HASH_W <= 12 so every window stays inside the top two bytes.
module mhf_index
    import mhf_pkg::*;
#(
    parameter int HASH_W = 12
) (
    input  win_mode_t           mode,
    input  logic [ADDR_W-1:0]   addr,
    output logic [HASH_W-1:0]   idx
);
    // Window select: three windows end near bit 47, one starts at bit 32.
    always_comb begin
        unique case (mode)
            WIN_TOP:      idx = addr[47 -: HASH_W];
            WIN_DOWN1:    idx = addr[46 -: HASH_W];
            WIN_DOWN2:    idx = addr[45 -: HASH_W];
            default:      idx = addr[32 +: HASH_W];
        endcase
    end
endmodule

// File: rtl/mhf_table.sv
// Module: hash bit table.
// NUM_WORDS words of WORD_W bits, with one write port, one software read port
// and one lookup read port. A clear strobe zeroes every word and takes
// priority over a same-cycle write. Both reads are combinational.
module mhf_table #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 128,
    localparam int SEL_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic [SEL_W-1:0]  lk_sel,
    output logic [WORD_W-1:0] lk_word
);
    logic [WORD_W-1:0] words [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        // Storage word: reset or clear to zero, otherwise load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                words[w] <= '0;
            else if (wr_en && wr_sel == SEL_W'(w))
                words[w] <= wr_data;
        end
    end

    // Read ports: plain selection of stored state.
    assign rd_data = words[rd_sel];
    assign lk_word = words[lk_sel];

    // R9: the cycle after a clear, every word reads back as zero.
    a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> rd_data == '0);
endmodule

// File: rtl/mhf_ctrl.sv
// Module: filter configuration register.
// Holds the global enable and the window mode. A clear forces the enable low
// and wins over the enable value of a same-cycle write. The mode is untouched
// by a clear.
module mhf_ctrl
    import mhf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       cfg_wr,
    input  logic       en_in,
    input  logic [1:0] mode_in,
    output logic       en,
    output win_mode_t  mode
);
    // Enable bit: cleared by reset or clear, loaded by a write.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            en <= 1'b0;
        else if (cfg_wr)
            en <= en_in;
    end

    // Mode field: loaded by a write only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= WIN_TOP;
        else if (cfg_wr)
            mode <= win_mode_t'(mode_in);
    end

    // R9: a clear always leaves the enable low.
    a_r9_clear_disables: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !en);
    // R10: a write without a clear loads both fields.
    a_r10_cfg_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !clear) |=> (en == $past(en_in)) && (mode == win_mode_t'($past(mode_in))));
endmodule

// File: rtl/mc_hash_filter.sv
// Module: multicast hash table filter (top).
// Hashes a destination address into a bit table and returns a registered
// accept flag one cycle after the strobe. Assumes the caller only presents
// multicast addresses. The lookup uses table and configuration state from
// before the edge at which it is captured.
module mc_hash_filter
    import mhf_pkg::*;
#(
    parameter int HASH_W    = 12,
    parameter int WORD_W    = 32,
    localparam int BIT_W    = $clog2(WORD_W),
    localparam int SEL_W    = HASH_W - BIT_W,
    localparam int NUM_WORDS = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_valid,
    input  logic [47:0]       dest_addr,
    input  logic              cfg_wr,
    input  logic              cfg_enable_in,
    input  logic [1:0]        cfg_mode_in,
    input  logic              table_clear,
    input  logic              tbl_wr,
    input  logic [SEL_W-1:0]  tbl_wr_sel,
    input  logic [WORD_W-1:0] tbl_wr_data,
    input  logic [SEL_W-1:0]  tbl_rd_sel,
    output logic [WORD_W-1:0] tbl_rd_data,
    output logic              cfg_enable,
    output logic [1:0]        cfg_mode,
    output logic              hit_valid,
    output logic              hit
);
    win_mode_t         mode_q;
    logic [HASH_W-1:0] hash_idx;
    logic [WORD_W-1:0] lk_word;

    mhf_ctrl i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (table_clear),
        .cfg_wr  (cfg_wr),
        .en_in   (cfg_enable_in),
        .mode_in (cfg_mode_in),
        .en      (cfg_enable),
        .mode    (mode_q)
    );

    assign cfg_mode = mode_q;

    mhf_index #(.HASH_W(HASH_W)) i_index (
        .mode (mode_q),
        .addr (dest_addr),
        .idx  (hash_idx)
    );

    mhf_table #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (table_clear),
        .wr_en   (tbl_wr),
        .wr_sel  (tbl_wr_sel),
        .wr_data (tbl_wr_data),
        .rd_sel  (tbl_rd_sel),
        .rd_data (tbl_rd_data),
        .lk_sel  (hash_idx[HASH_W-1:BIT_W]),
        .lk_word (lk_word)
    );

    // Result register: capture the strobe and the gated table bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_valid <= 1'b0;
            hit       <= 1'b0;
        end else begin
            hit_valid <= addr_valid;
            hit       <= addr_valid && cfg_enable && lk_word[hash_idx[BIT_W-1:0]];
        end
    end

    // R7: a strobe produces exactly one valid result one cycle later.
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> hit_valid);
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> !hit_valid);
    // R8: an accept requires the enable in the capturing cycle.
    a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(cfg_enable));
    // R11: an accept is always qualified.
    a_r11_hit_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> hit_valid);
endmodule

// File: tb/test_mc_hash_filter.sv
// Bench: directed and random stimulus, compared every cycle with a
// behavioural model of table, configuration and result.
module test_mc_hash_filter;
    localparam time PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_valid = 1'b0;
    logic [47:0] dest_addr = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_enable_in = 1'b0;
    logic [1:0]  cfg_mode_in = '0;
    logic        table_clear = 1'b0;
    logic        tbl_wr = 1'b0;
    logic [6:0]  tbl_wr_sel = '0;
    logic [31:0] tbl_wr_data = '0;
    logic [6:0]  tbl_rd_sel = '0;
    logic [31:0] tbl_rd_data;
    logic        cfg_enable;
    logic [1:0]  cfg_mode;
    logic        hit_valid;
    logic        hit;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit compare_on = 0;
    string phase = "R1";

    mc_hash_filter i_mc_hash_filter (.*);

    always #(PERIOD/2) clk = ~clk;

    // Reference model state.
    logic [31:0] m_tbl [128];
    logic        m_en, m_hv, m_hit;
    logic [1:0]  m_mode;

    function automatic int model_index(logic [47:0] a, logic [1:0] md);
        int sh;
        sh = (md == 0) ? 36 : (md == 1) ? 35 : (md == 2) ? 34 : 32;
        return int'((a >> sh) & 48'hFFF);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) m_tbl[i] <= '0;
            m_en <= 0; m_mode <= 0; m_hv <= 0; m_hit <= 0;
        end else begin
            int ix;
            ix = model_index(dest_addr, m_mode);
            m_hv  <= addr_valid;
            m_hit <= addr_valid && m_en && m_tbl[ix / 32][ix % 32];
            if (table_clear)
                for (int i = 0; i < 128; i++) m_tbl[i] <= '0;
            else if (tbl_wr)
                m_tbl[tbl_wr_sel] <= tbl_wr_data;
            if (cfg_wr) m_mode <= cfg_mode_in;
            if (table_clear) m_en <= 0;
            else if (cfg_wr) m_en <= cfg_enable_in;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (compare_on && !done) begin
            check({phase, " hit_valid"}, 32'(hit_valid), 32'(m_hv));
            check({phase, " hit"}, 32'(hit), 32'(m_hit));
            check("R10 read port", tbl_rd_data, m_tbl[tbl_rd_sel]);
            check("R9 enable", 32'(cfg_enable), 32'(m_en));
            check("R10 mode", 32'(cfg_mode), 32'(m_mode));
        end
    end

    task automatic next_cycle();
        @(posedge clk); #1;
        addr_valid = 0; cfg_wr = 0; table_clear = 0; tbl_wr = 0;
    endtask

    task automatic wr_word(logic [6:0] s, logic [31:0] d);
        tbl_wr = 1; tbl_wr_sel = s; tbl_wr_data = d;
        next_cycle();
    endtask

    task automatic set_cfg(logic e, logic [1:0] md);
        cfg_wr = 1; cfg_enable_in = e; cfg_mode_in = md;
        next_cycle();
    endtask

    task automatic lookup(logic [47:0] a, logic exp, string tag);
        addr_valid = 1; dest_addr = a;
        next_cycle();
        @(negedge clk);
        check(tag, 32'({hit_valid, hit}), 32'({1'b1, exp}));
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state seen at the ports.
        check("R1 hit_valid", 32'(hit_valid), 0);
        check("R1 enable", 32'(cfg_enable), 0);
        check("R1 mode", 32'(cfg_mode), 0);
        check("R1 word0", tbl_rd_data, 0);
        compare_on = 1;
        @(posedge clk); #1;

        // R2 and R6: index 0xABC -> word 0x55 bit 28.
        phase = "R2";
        wr_word(7'h55, 32'h1000_0000);
        set_cfg(1, 0);
        lookup(48'hABC0_0000_0000, 1, "R2 mode0 hit");
        lookup(48'hABB0_0000_0000, 0, "R6 neighbour bit miss");
        lookup(48'hABCF_FFFF_FFFF, 1, "R2 low bits ignored");

        // R3: index 0x123 -> word 9 bit 3.
        phase = "R3";
        wr_word(7'd9, 32'h0000_0008);
        set_cfg(1, 1);
        lookup(48'h123 << 35, 1, "R3 mode1 hit");
        lookup(48'h123 << 36, 0, "R3 mode1 shifted miss");

        // R4: index 0xFFF -> word 127 bit 31.
        phase = "R4";
        wr_word(7'd127, 32'h8000_0000);
        set_cfg(1, 2);
        lookup(48'hFFF << 34, 1, "R4 mode2 hit");

        // R5: index 0 -> word 0 bit 0; bits [47:44] ignored.
        phase = "R5";
        wr_word(7'd0, 32'h0000_0001);
        set_cfg(1, 3);
        lookup(48'hF000_0000_0000, 1, "R5 mode3 hit");
        lookup(48'hF001_0000_0000, 0, "R5 mode3 miss");

        // R8: disabled filter never accepts.
        phase = "R8";
        set_cfg(0, 3);
        lookup(48'hF000_0000_0000, 0, "R8 disabled");

        // R9: clear colliding with a write, a cfg write and a lookup.
        phase = "R9";
        set_cfg(1, 3);
        table_clear = 1; tbl_wr = 1; tbl_wr_sel = 7'd0; tbl_wr_data = 32'hFFFF_FFFF;
        cfg_wr = 1; cfg_enable_in = 1; cfg_mode_in = 0;
        addr_valid = 1; dest_addr = 48'h0;
        next_cycle();
        @(negedge clk);
        check("R9 lookup sees old state", 32'(hit), 1);
        check("R9 enable cleared", 32'(cfg_enable), 0);
        check("R9 mode still written", 32'(cfg_mode), 0);
        tbl_rd_sel = 7'h55;
        #1 check("R9 word zeroed", tbl_rd_data, 0);
        set_cfg(1, 0);
        lookup(48'hABC0_0000_0000, 0, "R9 after clear miss");

        // R7, R10, R11: random mix of all strobes, compared each cycle.
        phase = "R7";
        for (int n = 0; n < 3000; n++) begin
            addr_valid    = ($urandom % 2) == 0;
            dest_addr     = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            tbl_wr        = ($urandom % 3) == 0;
            tbl_wr_sel    = 7'($urandom);
            tbl_wr_data   = $urandom | $urandom;
            cfg_wr        = ($urandom % 16) == 0;
            cfg_enable_in = ($urandom % 4) != 0;
            cfg_mode_in   = 2'($urandom);
            table_clear   = ($urandom % 200) == 0;
            tbl_rd_sel    = 7'($urandom);
            @(posedge clk); #1;
        end
        next_cycle();
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule